// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Status Flags

This block is a combinational integer unit of parameterized width (8, 16 or 32 bits). An opcode selects addition, subtraction, compare, AND, OR, XOR or test. For each operation the unit produces a result, a set of six status flags and a write-enable. The write-enable tells the surrounding datapath whether to store the result. Compare and test produce flags only, so their write-enable is low.

A flag register sits beside the combinational path. On a rising clock edge it loads the new flags when the update strobe is high and the opcode is valid. Otherwise it keeps its value. Branch logic reads the register. It resets asynchronously to zero.

Top module: `alu_status_unit`

## Requirements
- R1: The flag vector has carry at bit 0, overflow at bit 1, zero at bit 2, sign at bit 3, parity at bit 4 and auxiliary carry at bit 5. Opcode 0 is add. Its result is (a+b) mod 2^W, and carry is set when the sum carries out of the top bit.
- R2: Opcode 1 (subtract) and opcode 2 (compare) both produce (a-b) mod 2^W. Carry is set when a < b as unsigned numbers, which is a borrow into the top bit.
- R3: Overflow is set on add when both operands have the same sign and the result's sign differs from them. On subtract and compare it is set when the operand signs differ and the result's sign differs from a's sign. In all other add, subtract and compare cases it is clear.
- R4: For every valid opcode, zero is set exactly when the result is all zeros, and sign equals the top bit of the result.
- R5: Parity is set when bits 7..0 of the result hold an even number of ones. Bits above 7 have no effect on it.
- R6: Auxiliary carry is set on add when the low nibbles of the operands sum above 15. On subtract and compare it is set when a's low nibble is below b's low nibble.
- R7: Opcodes 3 (AND), 4 (OR), 5 (XOR) and 6 (test, which computes AND) clear carry, overflow and auxiliary carry.
- R8: The write-enable is high for opcodes 0, 1, 3, 4 and 5. It is low for compare, test and opcode 7.
- R9: While the active-low reset is asserted, the flag register reads all zeros.
- R10: On a rising edge with the update strobe high and a valid opcode, the flag register loads the current flag vector.
- R11: On a rising edge with the update strobe low, the flag register keeps its value.
- R12: Opcode 7 is reserved. It drives a zero result and a zero flag vector, and it does not load the flag register even when the update strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the flag register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation select |
| a_i | input | W | First operand (minuend for subtraction) |
| b_i | input | W | Second operand |
| upd_i | input | 1 | Flag register update strobe |
| res_o | output | W | Operation result |
| wr_en_o | output | 1 | High when the result is to be stored |
| flags_o | output | 6 | Flags of the current operation |
| flag_q_o | output | 6 | Registered flags |

## Verification
The result, the current flags and the write-enable are combinational, so they are valid in the same cycle the operands arrive. The bench drives inputs on the falling edge and samples these outputs 1 ns later, before any clock edge. The registered flags change on the next rising edge, so the bench compares them 1 ns after that edge. It checks them against a model copy of the flag register, which loads only when the strobe is high and the opcode is valid.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_TEST = 3'd6,
    OP_RSVD = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } lg_sel_e;

  // bit order is part of the interface: {aux, par, sign, zero, ovf, carry}
  typedef struct packed {
    logic af;
    logic pf;
    logic sf;
    logic zf;
    logic of;
    logic cf;
  } flags_t;

  localparam int unsigned FLAG_W = $bits(flags_t);
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cf_o,
  output logic         of_o,
  output logic         af_o
);
  localparam int unsigned MSB = W - 1;

  logic [W:0] ext;
  logic [4:0] nib;

  always_comb begin
    if (sub_i) begin
      ext = {1'b0, a_i} - {1'b0, b_i};
      nib = {1'b0, a_i[3:0]} - {1'b0, b_i[3:0]};
    end else begin
      ext = {1'b0, a_i} + {1'b0, b_i};
      nib = {1'b0, a_i[3:0]} + {1'b0, b_i[3:0]};
    end
  end

  assign sum_o = ext[W-1:0];
  assign cf_o  = ext[W];
  assign af_o  = nib[4];

  // sign rule: operands agree (add) or disagree (sub), and result leaves a's sign
  always_comb begin
    if (sub_i) of_o = (a_i[MSB] ^ b_i[MSB]) & (sum_o[MSB] ^ a_i[MSB]);
    else       of_o = ~(a_i[MSB] ^ b_i[MSB]) & (sum_o[MSB] ^ a_i[MSB]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_status_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  lg_sel_e      sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i & b_i;
    endcase
  end
endmodule

// File: rtl/alu_res_flags.sv
module alu_res_flags #(
  parameter int unsigned W      = 32,
  parameter int unsigned PAR_W  = 8
) (
  input  logic [W-1:0] res_i,
  output logic         zf_o,
  output logic         sf_o,
  output logic         pf_o
);
  logic [PAR_W:0] par_chain;

  assign par_chain[0] = 1'b1;
  for (genvar i = 0; i < PAR_W; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ res_i[i];
  end

  assign zf_o = ~|res_i;
  assign sf_o = res_i[W-1];
  assign pf_o = par_chain[PAR_W];
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_status_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           op_i,
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  input  logic                 upd_i,
  output logic [W-1:0]         res_o,
  output logic                 wr_en_o,
  output logic [FLAG_W-1:0]    flags_o,
  output logic [FLAG_W-1:0]    flag_q_o
);
  localparam int unsigned PAR_W = 8;

  if (W < PAR_W) begin : g_bad_w
    $error("alu_status_unit: W must be at least 8");
  end

  op_e     op;
  logic    is_arith, is_sub, is_logic, is_valid;
  lg_sel_e lg_sel;

  logic [W-1:0] as_sum, lg_res;
  logic         as_cf, as_of, as_af;
  logic         zf, sf, pf;
  flags_t       fl, flag_q;

  assign op       = op_e'(op_i);
  assign is_sub   = (op == OP_SUB) || (op == OP_CMP);
  assign is_arith = (op == OP_ADD) || is_sub;
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_TEST);
  assign is_valid = (op != OP_RSVD);

  always_comb begin
    unique case (op)
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_AND;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (is_sub),
    .sum_o (as_sum),
    .cf_o  (as_cf),
    .of_o  (as_of),
    .af_o  (as_af)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (lg_sel),
    .res_o (lg_res)
  );

  always_comb begin
    if (is_arith)      res_o = as_sum;
    else if (is_logic) res_o = lg_res;
    else               res_o = '0;
  end

  alu_res_flags #(.W(W), .PAR_W(PAR_W)) u_res_flags (
    .res_i (res_o),
    .zf_o  (zf),
    .sf_o  (sf),
    .pf_o  (pf)
  );

  always_comb begin
    fl = '0;
    if (is_valid) begin
      fl.zf = zf;
      fl.sf = sf;
      fl.pf = pf;
    end
    if (is_arith) begin
      fl.cf = as_cf;
      fl.of = as_of;
      fl.af = as_af;
    end
  end

  assign flags_o = fl;
  assign wr_en_o = is_valid && (op != OP_CMP) && (op != OP_TEST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= '0;
    else if (upd_i && is_valid) flag_q <= fl;
  end

  assign flag_q_o = flag_q;

  // R4
  sign_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 3'd7) |-> (flags_o[3] == res_o[W-1]) && (flags_o[2] == (res_o == '0)));

  // R7
  logic_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 3'd3 && op_i <= 3'd6) |-> (flags_o[0] == 1'b0) && (flags_o[1] == 1'b0) && (flags_o[5] == 1'b0));

  // R8
  no_writeback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 || op_i == 3'd6 || op_i == 3'd7) |-> !wr_en_o);

  // R10
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i != 3'd7) |=> (flag_q_o == $past(flags_o)));

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flag_q_o));

  // R12
  reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd7) |-> (res_o == '0) && (flags_o == '0));

  // R12
  reserved_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd7) |=> $stable(flag_q_o));
endmodule

// File: tb/alu_status_unit_bench.sv
module alu_status_unit_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   op_i = '0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         upd_i = 1'b0;
  logic [W-1:0] res_o;
  logic         wr_en_o;
  logic [5:0]   flags_o;
  logic [5:0]   flag_q_o;

  int checks = 0;
  int failures = 0;
  logic [5:0] exp_q = '0;

  always #5 clk = ~clk;

  alu_status_unit #(.W(W)) u_alu_status_unit (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .upd_i    (upd_i),
    .res_o    (res_o),
    .wr_en_o  (wr_en_o),
    .flags_o  (flags_o),
    .flag_q_o (flag_q_o)
  );

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                                output logic [W-1:0] r, output logic [5:0] f, output logic we);
    longint ua, ub, sa, sb, t, st, pw, smax, smin;
    logic c, o, ax;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    pw = longint'(1) << W; smax = (pw >>> 1) - 1; smin = -(pw >>> 1);
    c = 0; o = 0; ax = 0; we = 0; r = '0;
    case (op)
      3'd0: begin
        t = ua + ub; r = t[W-1:0]; c = (t >= pw);
        st = sa + sb; o = (st > smax) || (st < smin);
        ax = ((ua % 16) + (ub % 16)) > 15; we = 1;
      end
      3'd1, 3'd2: begin
        t = ua - ub; r = t[W-1:0]; c = (ua < ub);
        st = sa - sb; o = (st > smax) || (st < smin);
        ax = (ua % 16) < (ub % 16); we = (op == 3'd1);
      end
      3'd3: begin r = a & b; we = 1; end
      3'd4: begin r = a | b; we = 1; end
      3'd5: begin r = a ^ b; we = 1; end
      3'd6: begin r = a & b; we = 0; end
      default: ;
    endcase
    if (op == 3'd7) f = '0;
    else f = {ax, ($countones(r[7:0]) % 2 == 0), r[W-1], (r == '0), o, c};
  endfunction

  task automatic run(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic upd, input string tag);
    logic [W-1:0] er;
    logic [5:0]   ef;
    logic         ewe;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; upd_i = upd;
    model(op, a, b, er, ef, ewe);
    #1;
    chk(res_o == er, {tag, " result"}, 64'(res_o), 64'(er));
    chk(flags_o == ef, {tag, " flags"}, 64'(flags_o), 64'(ef));
    chk(wr_en_o == ewe, "R8 write-enable", 64'(wr_en_o), 64'(ewe));
    if (upd && op != 3'd7) exp_q = ef;
    @(posedge clk); #1;
    chk(flag_q_o == exp_q, upd ? (op == 3'd7 ? "R12 no load" : "R10 load") : "R11 hold",
        64'(flag_q_o), 64'(exp_q));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #2;
    chk(flag_q_o == 6'd0, "R9 reset", 64'(flag_q_o), 64'd0);
    @(negedge clk); rst_ni = 1'b1;

    run(3'd0, 32'h0, 32'h0, 1, "R4 add zero");
    run(3'd0, 32'hFFFF_FFFF, 32'h1, 1, "R1 add carry");
    run(3'd0, 32'h7FFF_FFFF, 32'h1, 1, "R3 add overflow");
    run(3'd0, 32'h8000_0000, 32'h8000_0000, 1, "R3 neg+neg");
    run(3'd0, 32'h0000_000F, 32'h1, 1, "R6 nibble carry");
    run(3'd1, 32'h0, 32'h1, 1, "R2 borrow");
    run(3'd1, 32'h8000_0000, 32'h1, 1, "R3 sub overflow");
    run(3'd1, 32'h0000_0010, 32'h1, 1, "R6 nibble borrow");
    run(3'd2, 32'h1234_5678, 32'h1234_5678, 1, "R2 compare equal");
    run(3'd0, 32'hFF00_0000, 32'h0000_0003, 1, "R5 parity low byte");
    run(3'd5, 32'hFFFF_FF00, 32'h0000_0001, 1, "R5 parity odd");
    run(3'd3, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1, "R7 and zero");
    run(3'd4, 32'h8000_0000, 32'h0000_0001, 1, "R7 or sign");
    run(3'd6, 32'hFFFF_FFFF, 32'h8000_0080, 1, "R7 test");
    run(3'd7, 32'hFFFF_FFFF, 32'h1, 1, "R12 reserved");
    run(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R1 add no update");

    for (int i = 0; i < 400; i++) begin
      logic [2:0]   op;
      logic [W-1:0] a, b;
      op = 3'($urandom % 8);
      a = $urandom; b = $urandom;
      case ($urandom % 6)
        0: a = {1'b0, {(W-1){1'b1}}};
        1: b = {1'b1, {(W-1){1'b0}}};
        2: b = a;
        default: ;
      endcase
      run(op, a, b, 1'($urandom % 2), op < 3 ? "R3 random arith" : "R7 random logic");
    end

    @(negedge clk); rst_ni = 1'b0; #1;
    chk(flag_q_o == 6'd0, "R9 reset mid-run", 64'(flag_q_o), 64'd0);
    exp_q = '0;
    @(negedge clk); rst_ni = 1'b1;
    run(3'd1, 32'h5, 32'h9, 1, "R2 after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule